// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting Engine

The engine moves a programmed number of bytes between a host word port and a byte-wide NAND data bus through a 64-byte FIFO. In read mode it fetches bytes from the device ahead of the host and stops when the FIFO fills or the byte count runs out. In write mode it accepts 32-bit words posted by the host and drains them to the device one byte at a time. The device side is reduced to a ready input and a one-cycle strobe per byte.

Software or a DMA controller keeps the data moving by watching a FIFO count. In read mode this count gives the bytes waiting in the FIFO, and in write mode it gives the free space. A threshold status bit and a DMA request follow a programmable fill level, so the host can poll, take an interrupt, or move data in threshold-sized DMA frames. A count-complete status bit marks the end of a transfer. A stop input aborts the transfer at any time, and a start that arrives while a transfer is running is refused.

Top module: `nand_pf_engine`

## Requirements
- R1: After reset the engine is idle. busy_o, remain_o, fifo_cnt_o, irq_stat_o, irq_o, dma_req_o, ovf_o and both device strobes are 0.
- R2: A start request while idle latches length, direction (0 read, 1 write), threshold and DMA enable. It raises busy_o on the next edge, and remain_o then shows the length. A start request while busy raises start_rej_o in the same cycle and changes nothing.
- R3: In read mode, dev_rd_o is high in a cycle exactly when the engine is busy, remain_o is nonzero, the FIFO holds fewer than 64 bytes and dev_rdy_i is high. On that edge dev_rdata_i enters the FIFO and remain_o decrements by one.
- R4: host_rdata_o always shows the four oldest FIFO bytes, oldest in bits 7:0, with lanes beyond the fill level reading 0. A host read in busy read mode removes 4 bytes if at least 4 are held. If fewer than 4 are held and remain_o is 0, it removes all of them. Otherwise it removes nothing.
- R5: fifo_cnt_o gives the FIFO fill level in read mode and the free space (64 minus fill) in write mode. The mode is the one latched by the last accepted start.
- R6: In write mode, a host write while busy with at least 4 bytes free appends host_wdata_i, bits 7:0 first. dev_wr_o is high exactly when the engine is busy, the FIFO is not empty, remain_o is nonzero and dev_rdy_i is high. dev_wdata_o carries the oldest byte, which is removed, and remain_o decrements.
- R7: A host write in busy write mode with fewer than 4 bytes free is dropped and sets ovf_o. ovf_o stays set until the next accepted start clears it.
- R8: A transfer completes in the cycle where the engine is busy and remain_o is 0, with the FIFO also empty in read mode. On the next edge busy_o falls, the FIFO empties and irq_stat_o bit 1 sets.
- R9: While busy, irq_stat_o bit 0 is set on every edge on which the threshold level holds. The level is fill ≥ threshold in read mode and free space ≥ threshold in write mode.
- R10: Writing 1 to an irq_clr_i bit clears that status bit, but a set in the same cycle wins. irq_o is high when any status bit is set together with its irq_en_i bit.
- R11: dma_req_o is high exactly when the engine is busy, DMA is enabled and the threshold level holds.
- R12: stop_i returns the engine to idle on the next edge, with the FIFO empty and remain_o at 0. It wins over a start in the same cycle.
- R13: A host write in read mode or while idle, and a host read in write mode or while idle, leave the FIFO and the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_start_i | input | 1 | Start request (one cycle) |
| cfg_len_i | input | LEN_W | Transfer length in bytes |
| cfg_write_i | input | 1 | Direction: 0 read, 1 write |
| cfg_thresh_i | input | FILL_W | FIFO threshold in bytes |
| cfg_dma_en_i | input | 1 | Enable DMA request |
| stop_i | input | 1 | Abort and return to idle |
| start_rej_o | output | 1 | Start refused because busy |
| busy_o | output | 1 | Transfer active |
| host_wr_i | input | 1 | Host word write |
| host_wdata_i | input | 32 | Host write data |
| host_rd_i | input | 1 | Host word read (pop) |
| host_rdata_o | output | 32 | Oldest four FIFO bytes |
| fifo_cnt_o | output | FILL_W | Fill (read) or free space (write) |
| remain_o | output | LEN_W | Bytes still to move on the device side |
| irq_clr_i | input | 2 | Write-1-to-clear status |
| irq_en_i | input | 2 | Interrupt enables |
| irq_stat_o | output | 2 | Bit 0 threshold, bit 1 count complete |
| irq_o | output | 1 | Interrupt |
| dma_req_o | output | 1 | DMA request |
| ovf_o | output | 1 | Sticky host write overflow |
| dev_rdy_i | input | 1 | Device ready for a byte |
| dev_rd_o | output | 1 | Device read strobe |
| dev_rdata_i | input | 8 | Device read byte |
| dev_wr_o | output | 1 | Device write strobe |
| dev_wdata_o | output | 8 | Device write byte |

## Verification
The assertions check, on every cycle, the rules that link one cycle to the next. A device strobe always consumes exactly one count. Stop always lands in idle with a zero count. The overflow flag and the threshold status bit stay set until cleared. The fall of busy without a stop always leaves the count-complete bit set. The FIFO never takes in more than it has room for and never gives out more than it holds. Only the bench's scenarios show the data itself: byte order through the FIFO in both directions and the zero-padded tail of a read whose length is not a multiple of four. The scenarios also cover threshold and DMA levels under a random device ready, and refusal of a start while busy.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } xfer_dir_e;

  localparam int unsigned STAT_THR  = 0;
  localparam int unsigned STAT_DONE = 1;
endpackage

// File: rtl/pf_byte_fifo.sv
module pf_byte_fifo #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LANES  = 4,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned LN_W   = $clog2(LANES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic [LN_W-1:0]      push_n_i,
  input  logic [LANES*8-1:0]   push_data_i,
  input  logic [LN_W-1:0]      pop_n_i,
  output logic [LANES*8-1:0]   head_o,
  output logic [FILL_W-1:0]    fill_o
);
  logic [7:0]        mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (!flush_i && (LN_W'(k) < push_n_i))
        mem_q[wr_ptr_q + PTR_W'(k)] <= push_data_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(push_n_i);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n_i);
      fill_q   <= fill_q + FILL_W'(push_n_i) - FILL_W'(pop_n_i);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_head
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr_q + PTR_W'(k);
    assign head_o[8*k +: 8] = (FILL_W'(k) < fill_q) ? mem_q[idx] : 8'h00;
  end

  assign fill_o = fill_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && push_n_i != '0) |-> (32'(fill_q) + 32'(push_n_i) - 32'(pop_n_i) <= DEPTH))
    else $error("fifo push beyond depth");

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> (FILL_W'(pop_n_i) <= fill_q))
    else $error("fifo pop beyond fill");
endmodule

// File: rtl/pf_xfer_ctrl.sv
module pf_xfer_ctrl
  import nand_pf_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LEN_W  = 12,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              write_i,
  input  logic [FILL_W-1:0] thr_i,
  input  logic              dma_en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              dev_rdy_i,
  output logic              busy_o,
  output xfer_dir_e         dir_o,
  output logic [FILL_W-1:0] thr_o,
  output logic              dma_en_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic              done_o,
  output logic              start_ok_o,
  output logic              flush_o,
  output logic              dev_rd_o,
  output logic              dev_wr_o
);
  logic              busy_q, dma_q;
  xfer_dir_e         dir_q;
  logic [FILL_W-1:0] thr_q;
  logic [LEN_W-1:0]  remain_q;
  logic              cnt_zero;

  assign cnt_zero   = (remain_q == '0);
  assign start_ok_o = start_i && !busy_q && !stop_i;
  assign done_o     = busy_q && cnt_zero && (dir_q == DIR_WRITE || fill_i == '0);
  assign flush_o    = stop_i || start_ok_o || done_o;

  assign dev_rd_o = busy_q && dir_q == DIR_READ && !cnt_zero
                    && fill_i < FILL_W'(DEPTH) && dev_rdy_i;
  assign dev_wr_o = busy_q && dir_q == DIR_WRITE && !cnt_zero
                    && fill_i != '0 && dev_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      dir_q    <= DIR_READ;
      thr_q    <= '0;
      dma_q    <= 1'b0;
      remain_q <= '0;
    end else if (stop_i) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (start_ok_o) begin
      busy_q   <= 1'b1;
      dir_q    <= write_i ? DIR_WRITE : DIR_READ;
      thr_q    <= thr_i;
      dma_q    <= dma_en_i;
      remain_q <= len_i;
    end else if (done_o) begin
      busy_q   <= 1'b0;
    end else if (dev_rd_o || dev_wr_o) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign dir_o    = dir_q;
  assign thr_o    = thr_q;
  assign dma_en_o = dma_q;
  assign remain_o = remain_q;

  assert_dev_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dev_rd_o || dev_wr_o) && !stop_i) |=> (remain_o == $past(remain_o) - 1'b1))
    else $error("device strobe did not consume one count");

  assert_stop_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_o && remain_o == '0))
    else $error("stop did not return to idle");
endmodule

// File: rtl/pf_events.sv
module pf_events
  import nand_pf_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  xfer_dir_e         dir_i,
  input  logic [FILL_W-1:0] thr_i,
  input  logic              dma_en_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              done_i,
  input  logic              stop_i,
  input  logic [1:0]        clr_i,
  input  logic [1:0]        en_i,
  output logic [1:0]        stat_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic [1:0]        stat_q, stat_set;
  logic [FILL_W-1:0] level;
  logic              thr_hit;

  assign level   = (dir_i == DIR_WRITE) ? FILL_W'(DEPTH) - fill_i : fill_i;
  assign thr_hit = busy_i && (level >= thr_i);

  always_comb begin
    stat_set            = '0;
    stat_set[STAT_THR]  = thr_hit;
    stat_set[STAT_DONE] = done_i && !stop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | stat_set;
  end

  assign stat_o    = stat_q;
  assign irq_o     = |(stat_q & en_i);
  assign dma_req_o = thr_hit && dma_en_i;

  assert_stat_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[STAT_THR] && !clr_i[STAT_THR]) |=> stat_o[STAT_THR])
    else $error("threshold status lost without clear");

  assert_dma_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (busy_i && dma_en_i))
    else $error("dma request outside an enabled transfer");
endmodule

// File: rtl/nand_pf_engine.sv
module nand_pf_engine
  import nand_pf_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned HOST_BYTES = 4,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1),
  localparam int unsigned HW     = HOST_BYTES * 8,
  localparam int unsigned LN_W   = $clog2(HOST_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_start_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              cfg_write_i,
  input  logic [FILL_W-1:0] cfg_thresh_i,
  input  logic              cfg_dma_en_i,
  input  logic              stop_i,
  output logic              start_rej_o,
  output logic              busy_o,
  input  logic              host_wr_i,
  input  logic [HW-1:0]     host_wdata_i,
  input  logic              host_rd_i,
  output logic [HW-1:0]     host_rdata_o,
  output logic [FILL_W-1:0] fifo_cnt_o,
  output logic [LEN_W-1:0]  remain_o,
  input  logic [1:0]        irq_clr_i,
  input  logic [1:0]        irq_en_i,
  output logic [1:0]        irq_stat_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              ovf_o,
  input  logic              dev_rdy_i,
  output logic              dev_rd_o,
  input  logic [7:0]        dev_rdata_i,
  output logic              dev_wr_o,
  output logic [7:0]        dev_wdata_o
);
  xfer_dir_e         dir;
  logic [FILL_W-1:0] thr, fill, space;
  logic              dma_en, done, start_ok, flush;
  logic              host_push, ovf_set, ovf_q;
  logic [LN_W-1:0]   push_n, pop_n, host_pop_n;
  logic [HW-1:0]     push_data, head;

  pf_xfer_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni,
    .start_i(cfg_start_i), .stop_i,
    .len_i(cfg_len_i), .write_i(cfg_write_i), .thr_i(cfg_thresh_i), .dma_en_i(cfg_dma_en_i),
    .fill_i(fill), .dev_rdy_i,
    .busy_o, .dir_o(dir), .thr_o(thr), .dma_en_o(dma_en), .remain_o,
    .done_o(done), .start_ok_o(start_ok), .flush_o(flush),
    .dev_rd_o, .dev_wr_o
  );

  assign space     = FILL_W'(DEPTH) - fill;
  assign host_push = busy_o && dir == DIR_WRITE && host_wr_i && space >= FILL_W'(HOST_BYTES);
  assign ovf_set   = busy_o && dir == DIR_WRITE && host_wr_i && space <  FILL_W'(HOST_BYTES);

  always_comb begin
    host_pop_n = '0;
    if (busy_o && dir == DIR_READ && host_rd_i) begin
      if (fill >= FILL_W'(HOST_BYTES)) host_pop_n = LN_W'(HOST_BYTES);
      else if (remain_o == '0)         host_pop_n = LN_W'(fill);
    end
  end

  assign push_n    = host_push ? LN_W'(HOST_BYTES) : (dev_rd_o ? LN_W'(1) : '0);
  assign push_data = host_push ? host_wdata_i : HW'(dev_rdata_i);
  assign pop_n     = dev_wr_o ? LN_W'(1) : host_pop_n;

  pf_byte_fifo #(.DEPTH(DEPTH), .LANES(HOST_BYTES)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(flush), .push_n_i(push_n), .push_data_i(push_data),
    .pop_n_i(pop_n), .head_o(head), .fill_o(fill)
  );

  pf_events #(.DEPTH(DEPTH)) u_events (
    .clk_i, .rst_ni,
    .busy_i(busy_o), .dir_i(dir), .thr_i(thr), .dma_en_i(dma_en), .fill_i(fill),
    .done_i(done), .stop_i, .clr_i(irq_clr_i), .en_i(irq_en_i),
    .stat_o(irq_stat_o), .irq_o, .dma_req_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovf_q <= 1'b0;
    else if (start_ok) ovf_q <= 1'b0;
    else if (ovf_set)  ovf_q <= 1'b1;
  end

  assign ovf_o        = ovf_q;
  assign start_rej_o  = cfg_start_i && busy_o;
  assign host_rdata_o = head;
  assign dev_wdata_o  = head[7:0];
  assign fifo_cnt_o   = (dir == DIR_WRITE) ? space : fill;

  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(cfg_start_i && !busy_o && !stop_i)) |=> ovf_o)
    else $error("overflow flag dropped without a start");

  assert_done_stat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(stop_i)) |-> irq_stat_o[STAT_DONE])
    else $error("completion without count-complete status");

  assert_rej_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_rej_o && !stop_i) |=> ($past(remain_o) - remain_o <= 1))
    else $error("refused start altered the count");
endmodule

// File: tb/nand_pf_engine_tb.sv
module nand_pf_engine_tb;
  localparam int DEPTH = 64;
  localparam int LEN_W = 12;
  localparam int FILL_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start = 0, wr_dir = 0, dma = 0, stop = 0, hwr = 0, hrd = 0, rdy = 0;
  logic [LEN_W-1:0]  len = '0;
  logic [FILL_W-1:0] thr = '0;
  logic [31:0]       hwdata = '0;
  logic [1:0]        clr = '0, en = '0;
  logic [7:0]        dev_byte = 8'h10;

  logic              start_rej, busy, irq, dma_req, ovf, dev_rd, dev_wr;
  logic [31:0]       hrdata;
  logic [FILL_W-1:0] fifo_cnt;
  logic [LEN_W-1:0]  remain;
  logic [1:0]        stat;
  logic [7:0]        dev_wdata;

  nand_pf_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_start_i(start), .cfg_len_i(len), .cfg_write_i(wr_dir), .cfg_thresh_i(thr),
    .cfg_dma_en_i(dma), .stop_i(stop), .start_rej_o(start_rej), .busy_o(busy),
    .host_wr_i(hwr), .host_wdata_i(hwdata), .host_rd_i(hrd), .host_rdata_o(hrdata),
    .fifo_cnt_o(fifo_cnt), .remain_o(remain), .irq_clr_i(clr), .irq_en_i(en),
    .irq_stat_o(stat), .irq_o(irq), .dma_req_o(dma_req), .ovf_o(ovf),
    .dev_rdy_i(rdy), .dev_rd_o(dev_rd), .dev_rdata_i(dev_byte),
    .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done_run = 0;

  // reference model state
  byte unsigned q[$];
  bit m_busy = 0, m_dir = 0, m_dma = 0, m_ovf = 0;
  int m_thr = 0, m_remain = 0;
  bit [1:0] m_stat = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] wbyte = 8'h40;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int fill, space, popn, lvl_v;
    bit lvl, rd_s, wr_s, dn, sok, hpush, oset;
    logic [31:0] exp_rd;
    #1;
    fill  = q.size();
    space = DEPTH - fill;
    lvl_v = m_dir ? space : fill;
    lvl   = m_busy && (lvl_v >= m_thr);
    rd_s  = m_busy && !m_dir && m_remain != 0 && fill < DEPTH && rdy;
    wr_s  = m_busy && m_dir && m_remain != 0 && fill != 0 && rdy;
    dn    = m_busy && m_remain == 0 && (m_dir || fill == 0);
    sok   = start && !m_busy && !stop;
    hpush = m_busy && m_dir && hwr && space >= 4;
    oset  = m_busy && m_dir && hwr && space < 4;
    popn  = 0;
    if (m_busy && !m_dir && hrd) popn = (fill >= 4) ? 4 : ((m_remain == 0) ? fill : 0);
    exp_rd = '0;
    for (int k = 0; k < 4; k++) if (k < fill) exp_rd[8*k +: 8] = q[k];

    chk("R2", "busy_o", busy, m_busy);
    chk("R2", "start_rej_o", start_rej, start && m_busy);
    chk("R3", "remain_o", remain, m_remain);
    chk("R3", "dev_rd_o", dev_rd, rd_s);
    chk("R6", "dev_wr_o", dev_wr, wr_s);
    chk("R6", "dev_wdata_o", dev_wdata, exp_rd[7:0]);
    chk("R4", "host_rdata_o", hrdata, exp_rd);
    chk("R5", "fifo_cnt_o", fifo_cnt, lvl_v);
    chk("R9", "irq_stat_o", stat, m_stat);
    chk("R10", "irq_o", irq, |(m_stat & en));
    chk("R11", "dma_req_o", dma_req, lvl && m_dma);
    chk("R7", "ovf_o", ovf, m_ovf);

    m_stat = (m_stat & ~clr) | {dn && !stop, lvl};
    if (sok) m_ovf = 0; else if (oset) m_ovf = 1;
    if (stop) begin
      m_busy = 0; m_remain = 0; q.delete();
    end else if (sok) begin
      m_busy = 1; m_dir = wr_dir; m_thr = thr; m_dma = dma; m_remain = len; q.delete();
    end else if (dn) begin
      m_busy = 0; q.delete();
    end else begin
      for (int k = 0; k < popn; k++) void'(q.pop_front());
      if (wr_s) void'(q.pop_front());
      if (hpush) for (int k = 0; k < 4; k++) q.push_back(hwdata[8*k +: 8]);
      if (rd_s) q.push_back(dev_byte);
      if (rd_s || wr_s) m_remain--;
    end
    cycles++;
    @(negedge clk);
    if (rd_s) dev_byte++;
  endtask

  // rdy_mode: 0 low, 1 high, 2 pseudo-random
  task automatic auto(int n, bit rd_on, bit wr_on, int rdy_mode, bit until_idle);
    for (int i = 0; i < n; i++) begin
      if (until_idle && !m_busy) break;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = (rdy_mode == 1) || (rdy_mode == 2 && lfsr[0]);
      hrd = rd_on && m_busy && !m_dir && i[0] &&
            (q.size() >= 4 || (m_remain == 0 && q.size() > 0));
      hwr = wr_on && m_busy && m_dir && (DEPTH - q.size() >= 4);
      hwdata = {wbyte + 8'd3, wbyte + 8'd2, wbyte + 8'd1, wbyte};
      if (hwr) wbyte += 8'd4;
      cyc();
    end
    hrd = 0; hwr = 0; rdy = 0;
  endtask

  task automatic go(bit w, int l, int t, bit d);
    wr_dir = w; len = LEN_W'(l); thr = FILL_W'(t); dma = d; start = 1;
    cyc();
    start = 0;
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1", "busy_o", busy, 0);
    chk("R1", "remain_o", remain, 0);
    chk("R1", "fifo_cnt_o", fifo_cnt, 0);
    chk("R1", "irq_stat_o", stat, 0);
    chk("R1", "strobes", dev_rd | dev_wr | dma_req | ovf | irq, 0);
    @(negedge clk);

    // R13: host access while idle
    hwr = 1; hrd = 1; hwdata = 32'hDEADBEEF; cyc(); hwr = 0; hrd = 0;
    cyc();
    chk("R13", "fifo_cnt_o idle", fifo_cnt, 0);

    // read 42 bytes, odd tail, random ready, DMA on
    en = 2'b11;
    go(0, 42, 32, 1);
    chk("R2", "remain after start", remain, 42);
    auto(2000, 1, 0, 2, 1);
    cyc();
    chk("R8", "done status", stat[1], 1);
    chk("R8", "idle after read", busy, 0);
    clr = 2'b11; cyc(); clr = 0; cyc();
    chk("R10", "status cleared", stat, 0);

    // read 100 bytes, host idle: fills to 64 and stops fetching
    go(0, 100, 64, 0);
    auto(80, 0, 0, 1, 0);
    chk("R3", "fifo full", fifo_cnt, 64);
    chk("R3", "remain after fill", remain, 36);
    start = 1; len = 5; cyc(); start = 0;
    chk("R2", "refused start keeps remain", remain, 36);
    hwr = 1; hwdata = 32'h01020304; cyc(); hwr = 0;
    chk("R13", "write in read mode ignored", fifo_cnt, 64);
    auto(2000, 1, 0, 2, 1);

    // write 80 bytes, device stalled then overflow
    en = 2'b01;
    go(1, 80, 24, 1);
    auto(20, 0, 1, 0, 0);
    chk("R6", "space after posting", fifo_cnt, 0);
    hwr = 1; hwdata = 32'hFFFFFFFF; cyc(); hwr = 0;
    hrd = 1; cyc(); hrd = 0;
    chk("R7", "overflow flag", ovf, 1);
    chk("R13", "read in write mode ignored", fifo_cnt, 0);
    auto(4000, 0, 1, 2, 1);
    cyc();
    chk("R8", "write done", stat[1], 1);
    chk("R10", "done masked", irq, stat[0]);
    clr = 2'b11; cyc(); clr = 0;

    // stop mid-read, together with a start
    go(0, 30, 8, 0);
    chk("R7", "ovf cleared by start", ovf, 0);
    auto(6, 0, 0, 1, 0);
    stop = 1; start = 1; len = 7; cyc(); stop = 0; start = 0;
    chk("R12", "stop idle", busy, 0);
    chk("R12", "stop remain", remain, 0);
    chk("R12", "stop fifo", fifo_cnt, 0);
    cyc();

    // zero-length write completes at once
    go(1, 0, 4, 0);
    cyc();
    chk("R8", "zero length done", busy, 0);
    chk("R8", "zero length status", stat[1], 1);

    // read with threshold 1 and status clear racing a set
    clr = 2'b11; cyc(); clr = 0;
    go(0, 8, 1, 1);
    auto(4, 0, 0, 1, 0);
    clr = 2'b01; cyc(); clr = 0;
    chk("R10", "set wins over clear", stat[0], 1);
    auto(200, 1, 0, 1, 1);
    repeat (3) cyc();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule